// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit takes one jump-class instruction together with the operand values already read for it and decides where the program goes next. It reads the opcode, the 16-bit signed branch displacement, the 32-bit immediate, the two register operands and the current program counter. The program counter counts whole 64-bit instruction slots. From these it produces a taken flag and the next program counter. It also raises separate flags for a function call, a program return and an encoding that is not a legal jump.

The decision logic is purely combinational. A parameter places an optional register stage on every output; by default the stage is present. Compare width is chosen per instruction: one class compares full 64-bit values, and the other compares only the low 32 bits of each operand. Calls and returns are only flagged. They leave the program counter unchanged, so an outside sequencer can carry them out.

Top module: `cbr_unit`

## Requirements
- R1: Opcode bits [2:0] select the compare width. The value 5 compares all 64 operand bits. The value 6 compares only bits [31:0] of both operands, and in that case bit 31 is the sign for signed conditions.
- R2: Opcode bit 3 chooses the second operand. When it is 1 the source register value is used. When it is 0 the immediate is used, sign-extended from bit 31 to 64 bits.
- R3: Opcode bits [7:4] give the condition. Code 1 is taken when the operands are equal. Code 5 is taken when they differ. Code 4 is taken when the bitwise AND of the operands is nonzero.
- R4: Unsigned orderings of the first operand against the second: code 2 is greater, code 3 is greater-or-equal, code 10 is less and code 11 is less-or-equal.
- R5: Signed orderings of the first operand against the second: code 6 is greater, code 7 is greater-or-equal, code 12 is less and code 13 is less-or-equal.
- R6: Code 0 in the 64-bit class is always taken, whatever the operand values.
- R7: When the branch is taken, next PC = PC + 1 + the sign-extended displacement. When it is not taken, or the encoding is illegal, next PC = PC + 1. Both results wrap modulo 2^PC_W.
- R8: Code 8, in either class, raises the call flag. Code 9 in the 64-bit class raises the return flag. In both cases taken is 0 and next PC equals PC.
- R9: The illegal flag is raised in these cases: the class is not 5 or 6; the code is 14 or 15; or the code is 0 or 9 in the 32-bit class. When it is raised, taken, call and return are all 0.
- R10: With OUT_REG=1, every output shows the result for the inputs present at the preceding rising clock edge. A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction opcode: condition, operand select, class |
| offset | input | 16 | Signed branch displacement in instruction slots |
| imm | input | 32 | Immediate operand |
| dst_val | input | 64 | First compare operand (destination register value) |
| src_val | input | 64 | Source register value |
| pc | input | PC_W | Current program counter in instruction slots |
| taken | output | 1 | Branch is taken |
| next_pc | output | PC_W | Program counter of the next instruction |
| is_call | output | 1 | Instruction is a function call |
| is_exit | output | 1 | Instruction is a program return |
| illegal | output | 1 | Instruction is not a legal jump encoding |

## Verification
Every result is produced by a single register level: inputs applied before a rising edge appear on all five outputs just after that edge. The bench therefore drives each instruction on a falling edge and samples the outputs on the next falling edge, exactly one rising edge later. The reset check samples on the falling edge that follows a reset edge. The bound properties compare each output against the inputs seen one cycle earlier. They are active only in cycles whose previous cycle was out of reset.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int XLEN    = 64;
    localparam int HALF    = XLEN / 2;
    localparam int OFF_W   = 16;
    localparam int IMM_W   = 32;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        C_ALWAYS, C_EQ, C_GTU, C_GEU, C_SET, C_NE, C_GTS, C_GES,
        C_CALL, C_RET, C_LTU, C_LEU, C_LTS, C_LES, C_BAD
    } cond_e;

    typedef struct packed {
        logic  legal;
        logic  wide;
        logic  use_reg;
        cond_e cond;
    } jdec_t;

    typedef struct packed {
        logic eq;
        logic ltu;
        logic lts;
        logic anyset;
    } cmp_flags_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [7:0] opcode,
    output jdec_t      dec
);
    logic [2:0] cls;
    logic [3:0] code;
    logic       is_jcls;
    logic       narrow_only;

    assign cls  = opcode[2:0];
    assign code = opcode[7:4];
    assign is_jcls = (cls == CLS_WIDE) || (cls == CLS_NARROW);

    always_comb begin
        dec.cond = C_BAD;
        case (code)
            4'h0: dec.cond = C_ALWAYS;
            4'h1: dec.cond = C_EQ;
            4'h2: dec.cond = C_GTU;
            4'h3: dec.cond = C_GEU;
            4'h4: dec.cond = C_SET;
            4'h5: dec.cond = C_NE;
            4'h6: dec.cond = C_GTS;
            4'h7: dec.cond = C_GES;
            4'h8: dec.cond = C_CALL;
            4'h9: dec.cond = C_RET;
            4'hA: dec.cond = C_LTU;
            4'hB: dec.cond = C_LEU;
            4'hC: dec.cond = C_LTS;
            4'hD: dec.cond = C_LES;
            default: dec.cond = C_BAD;
        endcase
    end

    assign narrow_only = (code == 4'h0) || (code == 4'h9);
    assign dec.wide    = (cls == CLS_WIDE);
    assign dec.use_reg = opcode[3];
    assign dec.legal   = is_jcls && (dec.cond != C_BAD)
                         && !((cls == CLS_NARROW) && narrow_only);
endmodule

// File: rtl/cbr_compare.sv
module cbr_compare
    import cbr_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            wide,
    output cmp_flags_t      flags
);
    logic [XLEN-1:0] a_u, b_u;
    logic [XLEN-1:0] a_s, b_s;

    always_comb begin
        if (wide) begin
            a_u = a;
            b_u = b;
            a_s = a;
            b_s = b;
        end else begin
            a_u = {{(XLEN-HALF){1'b0}}, a[HALF-1:0]};
            b_u = {{(XLEN-HALF){1'b0}}, b[HALF-1:0]};
            a_s = {{(XLEN-HALF){a[HALF-1]}}, a[HALF-1:0]};
            b_s = {{(XLEN-HALF){b[HALF-1]}}, b[HALF-1:0]};
        end
    end

    assign flags.eq     = (a_u == b_u);
    assign flags.ltu    = (a_u < b_u);
    assign flags.lts    = ($signed(a_s) < $signed(b_s));
    assign flags.anyset = |(a_u & b_u);
endmodule

// File: rtl/cbr_nextpc.sv
module cbr_nextpc
    import cbr_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             taken,
    input  logic             hold,
    output logic [PC_W-1:0]  next_pc
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp;

    assign seq_pc = pc + PC_W'(1);
    assign disp   = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

    always_comb begin
        if (hold)       next_pc = pc;
        else if (taken) next_pc = seq_pc + disp;
        else            next_pc = seq_pc;
    end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       opcode,
    input  logic [15:0]      offset,
    input  logic [31:0]      imm,
    input  logic [63:0]      dst_val,
    input  logic [63:0]      src_val,
    input  logic [PC_W-1:0]  pc,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic             is_call,
    output logic             is_exit,
    output logic             illegal
);
    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] npc;
        logic            call;
        logic            ret;
        logic            bad;
    } res_t;

    jdec_t           dec;
    cmp_flags_t      fl;
    logic [XLEN-1:0] opnd_b;
    logic            cond_hit;
    logic            hold;
    res_t            res_c;
    res_t            res_q;

    cbr_decode u_dec (.opcode(opcode), .dec(dec));

    assign opnd_b = dec.use_reg ? src_val : widen_imm(imm);

    cbr_compare u_cmp (.a(dst_val), .b(opnd_b), .wide(dec.wide), .flags(fl));

    always_comb begin
        case (dec.cond)
            C_ALWAYS: cond_hit = 1'b1;
            C_EQ:     cond_hit = fl.eq;
            C_NE:     cond_hit = !fl.eq;
            C_SET:    cond_hit = fl.anyset;
            C_GTU:    cond_hit = !fl.ltu && !fl.eq;
            C_GEU:    cond_hit = !fl.ltu;
            C_LTU:    cond_hit = fl.ltu;
            C_LEU:    cond_hit = fl.ltu || fl.eq;
            C_GTS:    cond_hit = !fl.lts && !fl.eq;
            C_GES:    cond_hit = !fl.lts;
            C_LTS:    cond_hit = fl.lts;
            C_LES:    cond_hit = fl.lts || fl.eq;
            default:  cond_hit = 1'b0;
        endcase
    end

    assign res_c.bad   = !dec.legal;
    assign res_c.call  = dec.legal && (dec.cond == C_CALL);
    assign res_c.ret   = dec.legal && (dec.cond == C_RET);
    assign res_c.taken = dec.legal && cond_hit;
    assign hold        = res_c.call || res_c.ret;

    cbr_nextpc #(.PC_W(PC_W)) u_npc (
        .pc(pc), .offset(offset), .taken(res_c.taken),
        .hold(hold), .next_pc(res_c.npc)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_c;
            end
        end else begin : g_comb
            assign res_q = res_c;
        end
    endgenerate

    assign taken   = res_q.taken;
    assign next_pc = res_q.npc;
    assign is_call = res_q.call;
    assign is_exit = res_q.ret;
    assign illegal = res_q.bad;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int PC_W    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      opcode,
    input logic [PC_W-1:0] pc,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            is_call,
    input logic            is_exit,
    input logic            illegal
);
    generate
        if (OUT_REG) begin : g_chk
            assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
                $onehot0({taken, is_call, is_exit, illegal}));

            assert_hold_pc_R8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && (is_call || is_exit)) |-> (next_pc == $past(pc)));

            assert_seq_pc_R7: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !taken && !is_call && !is_exit)
                |-> (next_pc == PC_W'($past(pc) + PC_W'(1))));

            assert_uncond_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(opcode) == 8'h05) |-> taken);

            assert_narrow_bad_R9: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && ($past(opcode) == 8'h06 || $past(opcode) == 8'h96))
                |-> illegal);

            assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (!taken && !is_call && !is_exit && !illegal && next_pc == '0));
        end
    endgenerate
endmodule

bind cbr_unit cbr_checker #(.PC_W(PC_W), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst(rst), .opcode(opcode), .pc(pc),
    .taken(taken), .next_pc(next_pc), .is_call(is_call),
    .is_exit(is_exit), .illegal(illegal)
);

// File: tb/sim_cbr_unit.sv
`timescale 1ns/1ps
module sim_cbr_unit;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      opcode = '0;
    logic [15:0]     offset = '0;
    logic [31:0]     imm = '0;
    logic [63:0]     dst_val = '0;
    logic [63:0]     src_val = '0;
    logic [PC_W-1:0] pc = '0;
    logic            taken, is_call, is_exit, illegal;
    logic [PC_W-1:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cbr_unit #(.PC_W(PC_W), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .offset(offset), .imm(imm),
        .dst_val(dst_val), .src_val(src_val), .pc(pc), .taken(taken),
        .next_pc(next_pc), .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
    );

    // Expected result, written from the requirements: {taken, call, exit, illegal, next_pc}
    function automatic logic [PC_W+3:0] model(input logic [7:0] op, input logic [15:0] off,
                                             input logic [31:0] im, input logic [63:0] d,
                                             input logic [63:0] s, input logic [PC_W-1:0] p);
        logic [2:0]  cls = op[2:0];
        logic [3:0]  code = op[7:4];
        logic [63:0] b = op[3] ? s : {{32{im[31]}}, im};
        logic bad, c, e, t;
        logic [PC_W-1:0] n;
        bad = !(cls == 3'd5 || cls == 3'd6) || code >= 4'd14
              || (cls == 3'd6 && (code == 4'd0 || code == 4'd9));
        c = 0; e = 0; t = 0;
        if (!bad) begin
            if (cls == 3'd5) begin
                case (code)
                    0: t = 1;
                    1: t = d == b;      5: t = d != b;     4: t = (d & b) != 0;
                    2: t = d > b;       3: t = d >= b;     10: t = d < b;  11: t = d <= b;
                    6: t = $signed(d) > $signed(b);   7: t = $signed(d) >= $signed(b);
                    12: t = $signed(d) < $signed(b);  13: t = $signed(d) <= $signed(b);
                    8: c = 1;           9: e = 1;
                    default: t = 0;
                endcase
            end else begin
                case (code)
                    1: t = d[31:0] == b[31:0];  5: t = d[31:0] != b[31:0];
                    4: t = (d[31:0] & b[31:0]) != 0;
                    2: t = d[31:0] > b[31:0];   3: t = d[31:0] >= b[31:0];
                    10: t = d[31:0] < b[31:0];  11: t = d[31:0] <= b[31:0];
                    6: t = $signed(d[31:0]) > $signed(b[31:0]);
                    7: t = $signed(d[31:0]) >= $signed(b[31:0]);
                    12: t = $signed(d[31:0]) < $signed(b[31:0]);
                    13: t = $signed(d[31:0]) <= $signed(b[31:0]);
                    8: c = 1;
                    default: t = 0;
                endcase
            end
        end
        if (c || e)  n = p;
        else if (t)  n = p + PC_W'(1) + {{(PC_W-16){off[15]}}, off};
        else         n = p + PC_W'(1);
        return {t, c, e, bad, n};
    endfunction

    task automatic compare(input string req, input logic [PC_W+3:0] exp);
        logic [PC_W+3:0] act = {taken, is_call, is_exit, illegal, next_pc};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual t/c/e/i=%b next=%h expected t/c/e/i=%b next=%h",
                     req, act[PC_W+3:PC_W], act[PC_W-1:0], exp[PC_W+3:PC_W], exp[PC_W-1:0]);
        end
    endtask

    // Drive on a falling edge, result due after the next rising edge; sample one falling edge later.
    task automatic run(input string req, input logic [7:0] op, input logic [15:0] off,
                       input logic [31:0] im, input logic [63:0] d, input logic [63:0] s,
                       input logic [PC_W-1:0] p, input logic exp_taken);
        logic [PC_W+3:0] exp = model(op, off, im, d, s, p);
        @(negedge clk);
        opcode = op; offset = off; imm = im; dst_val = d; src_val = s; pc = p;
        @(negedge clk);
        compare(req, exp);
        checks++;
        if (exp[PC_W+3] !== exp_taken) begin
            errors++;
            $display("FAIL %s: bench expectation taken=%b disagrees with scenario %b",
                     req, exp[PC_W+3], exp_taken);
        end
    endtask

    task automatic t_reset_R10;
        @(negedge clk);
        rst = 1'b1; opcode = 8'h05; pc = 32'h1234;
        @(negedge clk);
        compare("R10 reset", '0);
        rst = 1'b0;
        run("R10 latency", 8'h05, 16'd3, 0, 0, 0, 32'h10, 1'b1);
    endtask

    task automatic t_equality_R3;
        run("R3 eq hit",  8'h1D, 16'd4, 0, 64'hDEAD, 64'hDEAD, 32'h100, 1'b1);
        run("R3 eq miss", 8'h1D, 16'd4, 0, 64'hDEAD, 64'hBEEF, 32'h100, 1'b0);
        run("R3 ne hit",  8'h5D, 16'd4, 0, 64'h1, 64'h2, 32'h100, 1'b1);
        run("R3 set hit", 8'h4D, 16'd2, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 32'h20, 1'b1);
        run("R3 set miss",8'h4D, 16'd2, 0, 64'hF0, 64'h0F, 32'h20, 1'b0);
    endtask

    task automatic t_unsigned_R4;
        run("R4 gtu", 8'h2D, 16'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'h40, 1'b1);
        run("R4 geu eq", 8'h3D, 16'd1, 0, 64'h7, 64'h7, 32'h40, 1'b1);
        run("R4 ltu", 8'hAD, 16'd1, 0, 64'h7, 64'h7, 32'h40, 1'b0);
        run("R4 leu", 8'hBD, 16'd1, 0, 64'h7, 64'h7, 32'h40, 1'b1);
    endtask

    task automatic t_signed_R5;
        run("R5 gts neg", 8'h6D, 16'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'h40, 1'b0);
        run("R5 ges",     8'h7D, 16'd1, 0, 64'h5, 64'hFFFF_FFFF_FFFF_FFFB, 32'h40, 1'b1);
        run("R5 lts",     8'hCD, 16'd1, 0, 64'h8000_0000_0000_0000, 64'h0, 32'h40, 1'b1);
        run("R5 les",     8'hDD, 16'd1, 0, 64'h3, 64'h2, 32'h40, 1'b0);
    endtask

    task automatic t_width_R1;
        // upper halves differ, low halves equal: 32-bit equal, 64-bit not
        run("R1 narrow eq", 8'h1E, 16'd5, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h80, 1'b1);
        run("R1 wide eq",   8'h1D, 16'd5, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h80, 1'b0);
        // bit 31 is the sign in narrow compares
        run("R1 narrow lts",8'hCE, 16'd5, 0, 64'h0000_0000_8000_0000, 64'h1, 32'h80, 1'b1);
        run("R1 wide lts",  8'hCD, 16'd5, 0, 64'h0000_0000_8000_0000, 64'h1, 32'h80, 1'b0);
    endtask

    task automatic t_operand_R2;
        // immediate -1 sign-extends to all ones
        run("R2 imm sext",  8'h15, 16'd6, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h50, 1'b1);
        run("R2 imm vs reg",8'h1D, 16'd6, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h50, 1'b0);
        run("R2 imm gtu",   8'h25, 16'd6, 32'h0000_0010, 64'h11, 64'hFFFF, 32'h50, 1'b1);
    endtask

    task automatic t_uncond_R6;
        run("R6 always",  8'h05, 16'h7FFF, 0, 64'h0, 64'h0, 32'h0, 1'b1);
        run("R6 always x",8'h0D, 16'h8000, 0, 64'h9, 64'h3, 32'h9000, 1'b1);
    endtask

    task automatic t_nextpc_R7;
        run("R7 back",    8'h05, 16'hFFFB, 0, 0, 0, 32'h2, 1'b1);
        run("R7 to self", 8'h05, 16'hFFFF, 0, 0, 0, 32'h0, 1'b1);
        run("R7 wrap",    8'h1D, 16'd9, 0, 64'h1, 64'h2, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_callret_R8;
        run("R8 call wide",   8'h85, 16'd7, 32'd1, 64'h1, 64'h1, 32'h300, 1'b0);
        run("R8 call narrow", 8'h86, 16'd7, 32'd1, 64'h1, 64'h1, 32'h301, 1'b0);
        run("R8 exit",        8'h95, 16'd7, 0, 64'h0, 64'h0, 32'h302, 1'b0);
    endtask

    task automatic t_illegal_R9;
        run("R9 ja narrow",   8'h06, 16'd3, 0, 0, 0, 32'h400, 1'b0);
        run("R9 exit narrow", 8'h96, 16'd3, 0, 0, 0, 32'h401, 1'b0);
        run("R9 code e",      8'hE5, 16'd3, 0, 0, 0, 32'h402, 1'b0);
        run("R9 code f",      8'hFD, 16'd3, 0, 0, 0, 32'h403, 1'b0);
        run("R9 alu class",   8'h07, 16'd3, 0, 0, 0, 32'h404, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset_R10;
                t_equality_R3;
                t_unsigned_R4;
                t_signed_R5;
                t_width_R1;
                t_operand_R2;
                t_uncond_R6;
                t_nextpc_R7;
                t_callret_R8;
                t_illegal_R9;
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule